// File: doc/BRIEF.md
# Text Overlay Row and Cell Sequencer

This block walks a fixed text page across the picture in step with the incoming line and field sync. It turns the picture position into the address of the character cell being drawn: the memory row and column, and the pixel column and pixel line inside that cell's glyph. The page is 25 text rows of 40 cells. Each glyph is 12 pixels wide and 10 lines high, and each glyph line takes one TV line in every field. A glyph renderer downstream uses these outputs to read the character store and the glyph shapes. The block also flags character codes that must be drawn as blanks.

The page window starts a programmable number of pixel clocks after each line sync edge. It starts a programmable number of lines after each field sync edge. A control input moves the status row, memory row 24, to the top of the page, with rows 0 to 23 following it. Sync inputs are expected to be synchronous to the pixel clock.

Top module: `txt_row_cell_seq`

## Requirements
- R1: The page has COLS (40) cells across and ROWS (25) text rows down. `mem_col` steps 0, 1, … COLS-1 from left to right and advances once every CELL_W (12) enabled pixels.
- R2: When `status_top` is 0, `mem_row` equals the displayed row index. When it is 1, displayed row 0 reads memory row ROWS-1, and displayed row k (k ≥ 1) reads memory row k-1.
- R3: `glyph_x` counts 0 to CELL_W-1 across each cell, one step per enabled pixel clock, and returns to 0 at the start of the next cell.
- R4: `glyph_y` counts 0 to CELL_H-1 (10) down each text row, one step per line sync edge inside the page window. Every field sync edge restarts the page from row 0.
- R5: A clock edge that samples `hsync` rising is counted as pixel 0 of the line. On a line inside the page window, `disp_en` is high for pixels `h_offset` through `h_offset`+COLS·CELL_W-1 and low for all other pixels.
- R6: After a field sync rising edge, the line syncs are numbered from 0. Lines `v_offset` through `v_offset`+ROWS·CELL_H-1 are inside the page window. No other line asserts `disp_en`, and no line does so before the first field sync after reset.
- R7: `ctl_blank` is high exactly when `disp_en` is high and `char_code` is below 0x20.
- R8: While `disp_en` is low, `mem_col` and `glyph_x` keep their last values. Outside the vertical window, `glyph_y` and the displayed row keep their last values. `mem_row` then follows the held row through the R2 mapping.
- R9: While reset is asserted, and until the first field sync, `disp_en` and `ctl_blank` are 0. During reset all address and glyph outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Line sync, rising edge starts a line |
| vsync | input | 1 | Field sync, rising edge starts a field |
| status_top | input | 1 | 1 shows the status row first |
| h_offset | input | HOFF_W | Pixel clocks from line sync to first cell |
| v_offset | input | VOFF_W | Lines from field sync to first text row |
| char_code | input | 8 | Character code read from memory |
| disp_en | output | 1 | High inside the page window |
| mem_row | output | $clog2(ROWS) | Memory row being drawn |
| mem_col | output | $clog2(COLS) | Memory column being drawn |
| glyph_x | output | $clog2(CELL_W) | Pixel column inside the glyph |
| glyph_y | output | $clog2(CELL_H) | Pixel line inside the glyph |
| ctl_blank | output | 1 | Current code must be shown as a space |

## Verification
The hardest states to reach are the window edges: the last pixel of the last cell on the last glyph line of the last row, and the pixel clock just after the window closes, where the outputs must freeze instead of wrapping. The bench shrinks the page to a few cells and rows. It then sweeps whole fields for several combinations of horizontal offset, vertical offset and status-row placement, including zero offsets, so that every window corner occurs many times. On every pixel clock it compares all outputs with a position model built from the sync edges it has driven. The character code it drives crosses the 0x1F/0x20 boundary and wraps through 0xFF inside active cells.

// File: rtl/txo_pkg.sv
package txo_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LEAD = 2'd1,
    SEQ_DRAW = 2'd2
  } seq_state_e;

  localparam logic [7:0] CTRL_CODE_TOP = 8'h20;

endpackage

// File: rtl/txo_rst_sync.sv
module txo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= {shift_q[0], 1'b1};
  end

  assign rst_n_sync = shift_q[1];

endmodule

// File: rtl/txo_hseq.sv
module txo_hseq
  import txo_pkg::*;
#(
  parameter int COLS   = 40,
  parameter int CELL_W = 12,
  parameter int HOFF_W = 10,
  localparam int CW    = $clog2(COLS),
  localparam int XW    = $clog2(CELL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              run_en,
  input  logic [HOFF_W-1:0] h_offset,
  output logic              h_act,
  output logic [CW-1:0]     col,
  output logic [XW-1:0]     px
);

  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);
  localparam logic [XW-1:0] PX_LAST  = XW'(CELL_W - 1);

  seq_state_e        st_q, st_d;
  logic [HOFF_W-1:0] lead_q, lead_d, lead_inc;
  logic [CW-1:0]     col_q, col_d;
  logic [XW-1:0]     px_q, px_d;
  logic              reg_en;

  assign lead_inc = lead_q + HOFF_W'(1);

  always_comb begin
    st_d   = st_q;
    lead_d = lead_q;
    col_d  = col_q;
    px_d   = px_q;
    if (!run_en) begin
      st_d = SEQ_IDLE;
    end else if (line_start) begin
      lead_d = '0;
      if (h_offset == '0) begin
        st_d  = SEQ_DRAW;
        col_d = '0;
        px_d  = '0;
      end else begin
        st_d = SEQ_LEAD;
      end
    end else begin
      case (st_q)
        SEQ_LEAD: begin
          if (lead_inc == h_offset) begin
            st_d  = SEQ_DRAW;
            col_d = '0;
            px_d  = '0;
          end else begin
            lead_d = lead_inc;
          end
        end
        SEQ_DRAW: begin
          if (px_q == PX_LAST) begin
            if (col_q == COL_LAST) begin
              st_d = SEQ_IDLE;
            end else begin
              px_d  = '0;
              col_d = col_q + CW'(1);
            end
          end else begin
            px_d = px_q + XW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign reg_en = (st_d != st_q) || (st_q != SEQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      lead_q <= '0;
      col_q  <= '0;
      px_q   <= '0;
    end else if (reg_en) begin
      st_q   <= st_d;
      lead_q <= lead_d;
      col_q  <= col_d;
      px_q   <= px_d;
    end
  end

  assign h_act = (st_q == SEQ_DRAW);
  assign col   = col_q;
  assign px    = px_q;

  p_col_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= COL_LAST);

  p_px_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    px_q <= PX_LAST);

  p_px_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_act && run_en && !line_start && px_q != PX_LAST)
      |=> (h_act && px_q == XW'($past(px_q) + XW'(1))));

  p_col_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_act && $past(!h_act)) |-> ($stable(col_q) && $stable(px_q)));

endmodule

// File: rtl/txo_vseq.sv
module txo_vseq
  import txo_pkg::*;
#(
  parameter int ROWS   = 25,
  parameter int CELL_H = 10,
  parameter int VOFF_W = 9,
  localparam int RW    = $clog2(ROWS),
  localparam int YW    = $clog2(CELL_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start,
  input  logic              line_start,
  input  logic [VOFF_W-1:0] v_offset,
  output logic              v_act,
  output logic              draw_nxt,
  output logic [RW-1:0]     row,
  output logic [YW-1:0]     line
);

  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [YW-1:0] LN_LAST  = YW'(CELL_H - 1);

  seq_state_e        st_q, st_d;
  logic [VOFF_W-1:0] lead_q, lead_d;
  logic [RW-1:0]     row_q, row_d;
  logic [YW-1:0]     line_q, line_d;
  logic              reg_en;

  always_comb begin
    st_d   = st_q;
    lead_d = lead_q;
    row_d  = row_q;
    line_d = line_q;
    if (field_start) begin
      st_d   = SEQ_LEAD;
      lead_d = '0;
    end else if (line_start) begin
      case (st_q)
        SEQ_LEAD: begin
          if (lead_q == v_offset) begin
            st_d   = SEQ_DRAW;
            row_d  = '0;
            line_d = '0;
          end else begin
            lead_d = lead_q + VOFF_W'(1);
          end
        end
        SEQ_DRAW: begin
          if (line_q == LN_LAST) begin
            if (row_q == ROW_LAST) begin
              st_d = SEQ_IDLE;
            end else begin
              line_d = '0;
              row_d  = row_q + RW'(1);
            end
          end else begin
            line_d = line_q + YW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign reg_en = field_start || line_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      lead_q <= '0;
      row_q  <= '0;
      line_q <= '0;
    end else if (reg_en) begin
      st_q   <= st_d;
      lead_q <= lead_d;
      row_q  <= row_d;
      line_q <= line_d;
    end
  end

  assign v_act    = (st_q == SEQ_DRAW);
  assign draw_nxt = (st_d == SEQ_DRAW);
  assign row      = row_q;
  assign line     = line_q;

  p_row_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= ROW_LAST);

  p_line_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_q <= LN_LAST);

  p_line_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (v_act && line_start && !field_start && line_q != LN_LAST)
      |=> (v_act && line_q == YW'($past(line_q) + YW'(1))));

  p_row_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!v_act && $past(!v_act)) |-> ($stable(row_q) && $stable(line_q)));

endmodule

// File: rtl/txo_rowmap.sv
module txo_rowmap #(
  parameter int ROWS = 25,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          status_top,
  input  logic [RW-1:0] disp_row,
  output logic [RW-1:0] mem_row
);

  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

  always_comb begin
    if (status_top) begin
      if (disp_row == '0) mem_row = ROW_LAST;
      else                mem_row = disp_row - RW'(1);
    end else begin
      mem_row = disp_row;
    end
    p_map_bound_r2: assert (mem_row <= ROW_LAST || disp_row > ROW_LAST);
  end

endmodule

// File: rtl/txt_row_cell_seq.sv
module txt_row_cell_seq
  import txo_pkg::*;
#(
  parameter int COLS   = 40,
  parameter int ROWS   = 25,
  parameter int CELL_W = 12,
  parameter int CELL_H = 10,
  parameter int HOFF_W = 10,
  parameter int VOFF_W = 9,
  localparam int CW    = $clog2(COLS),
  localparam int RW    = $clog2(ROWS),
  localparam int XW    = $clog2(CELL_W),
  localparam int YW    = $clog2(CELL_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              status_top,
  input  logic [HOFF_W-1:0] h_offset,
  input  logic [VOFF_W-1:0] v_offset,
  input  logic [7:0]        char_code,
  output logic              disp_en,
  output logic [RW-1:0]     mem_row,
  output logic [CW-1:0]     mem_col,
  output logic [XW-1:0]     glyph_x,
  output logic [YW-1:0]     glyph_y,
  output logic              ctl_blank
);

  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

  logic          srst_n;
  logic          hs_q, vs_q;
  logic          hs_edge, vs_edge;
  logic          v_act, v_draw_nxt;
  logic [RW-1:0] disp_row;

  txo_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (srst_n)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
    end
  end

  assign hs_edge = hsync & ~hs_q;
  assign vs_edge = vsync & ~vs_q;

  txo_vseq #(
    .ROWS   (ROWS),
    .CELL_H (CELL_H),
    .VOFF_W (VOFF_W)
  ) u_vseq (
    .clk         (clk),
    .rst_n       (srst_n),
    .field_start (vs_edge),
    .line_start  (hs_edge),
    .v_offset    (v_offset),
    .v_act       (v_act),
    .draw_nxt    (v_draw_nxt),
    .row         (disp_row),
    .line        (glyph_y)
  );

  txo_hseq #(
    .COLS   (COLS),
    .CELL_W (CELL_W),
    .HOFF_W (HOFF_W)
  ) u_hseq (
    .clk        (clk),
    .rst_n      (srst_n),
    .line_start (hs_edge),
    .run_en     (v_draw_nxt),
    .h_offset   (h_offset),
    .h_act      (disp_en),
    .col        (mem_col),
    .px         (glyph_x)
  );

  txo_rowmap #(
    .ROWS (ROWS)
  ) u_rowmap (
    .status_top (status_top),
    .disp_row   (disp_row),
    .mem_row    (mem_row)
  );

  assign ctl_blank = disp_en & (char_code < CTRL_CODE_TOP);

  p_en_in_window_r6: assert property (@(posedge clk) disable iff (!srst_n)
    disp_en |-> v_act);

  p_blank_gated_r7: assert property (@(posedge clk) disable iff (!srst_n)
    ctl_blank |-> disp_en);

  p_status_first_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (status_top && disp_row == '0) |-> (mem_row == ROW_LAST));

  p_field_restart_r4: assert property (@(posedge clk) disable iff (!srst_n)
    vs_edge |=> !disp_en);

endmodule

// File: tb/txt_row_cell_seq_tb.sv
module txt_row_cell_seq_tb;

  localparam int COLS   = 5;
  localparam int ROWS   = 4;
  localparam int CELL_W = 3;
  localparam int CELL_H = 2;
  localparam int HOFF_W = 4;
  localparam int VOFF_W = 3;
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);
  localparam int XW = $clog2(CELL_W);
  localparam int YW = $clog2(CELL_H);

  logic              clk;
  logic              rst_n;
  logic              hsync, vsync, status_top;
  logic [HOFF_W-1:0] h_offset;
  logic [VOFF_W-1:0] v_offset;
  logic [7:0]        char_code;
  logic              disp_en, ctl_blank;
  logic [RW-1:0]     mem_row;
  logic [CW-1:0]     mem_col;
  logic [XW-1:0]     glyph_x;
  logic [YW-1:0]     glyph_y;

  txt_row_cell_seq #(
    .COLS(COLS), .ROWS(ROWS), .CELL_W(CELL_W), .CELL_H(CELL_H),
    .HOFF_W(HOFF_W), .VOFF_W(VOFF_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .status_top(status_top), .h_offset(h_offset), .v_offset(v_offset),
    .char_code(char_code), .disp_en(disp_en), .mem_row(mem_row),
    .mem_col(mem_col), .glyph_x(glyph_x), .glyph_y(glyph_y),
    .ctl_blank(ctl_blank)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int  n_chk, n_bad;
  bit  done;
  int  t_pix, l_idx;
  bit  armed;
  bit  hs_last, vs_last;
  int  hs_cfg, vs_cfg;
  int  e_col, e_px, e_row, e_ln;
  int  salt;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int map_row(input int r, input bit top);
    if (!top) return r;
    return (r == 0) ? ROWS - 1 : r - 1;
  endfunction

  task automatic step();
    bit hs_ev, vs_ev, v_in, h_in, e_act, e_blk;
    @(negedge clk);
    hs_ev = hsync && !hs_last;
    vs_ev = vsync && !vs_last;
    hs_last = hsync;
    vs_last = vsync;
    if (vs_ev) begin
      armed = 1'b1;
      l_idx = -1;
      t_pix = t_pix + 1;
    end else if (hs_ev) begin
      if (armed) l_idx = l_idx + 1;
      t_pix = 0;
    end else begin
      t_pix = t_pix + 1;
    end
    v_in  = armed && l_idx >= vs_cfg && l_idx < vs_cfg + ROWS * CELL_H;
    h_in  = t_pix >= hs_cfg && t_pix < hs_cfg + COLS * CELL_W;
    e_act = v_in && h_in;
    if (v_in) begin
      e_row = (l_idx - vs_cfg) / CELL_H;
      e_ln  = (l_idx - vs_cfg) % CELL_H;
    end
    if (e_act) begin
      e_col = (t_pix - hs_cfg) / CELL_W;
      e_px  = (t_pix - hs_cfg) % CELL_W;
    end
    e_blk = e_act && (char_code < 8'h20);
    chk(disp_en == e_act, v_in ? "R5" : "R6", "disp_en", int'(disp_en), int'(e_act));
    chk(int'(mem_col) == e_col, e_act ? "R1" : "R8", "mem_col", int'(mem_col), e_col);
    chk(int'(glyph_x) == e_px, e_act ? "R3" : "R8", "glyph_x", int'(glyph_x), e_px);
    chk(int'(glyph_y) == e_ln, v_in ? "R4" : "R8", "glyph_y", int'(glyph_y), e_ln);
    chk(int'(mem_row) == map_row(e_row, status_top), "R2", "mem_row",
        int'(mem_row), map_row(e_row, status_top));
    chk(ctl_blank == e_blk, "R7", "ctl_blank", int'(ctl_blank), int'(e_blk));
    char_code = 8'(salt + t_pix + 1);
  endtask

  task automatic run_field(input int hs, input int vs, input bit top, input int s);
    hs_cfg = hs;
    vs_cfg = vs;
    salt   = s;
    h_offset   = HOFF_W'(hs);
    v_offset   = VOFF_W'(vs);
    status_top = top;
    step();
    vsync = 1'b1;
    step();
    vsync = 1'b0;
    step();
    step();
    for (int ln = 0; ln < vs + ROWS * CELL_H + 2; ln++) begin
      hsync = 1'b1;
      step();
      hsync = 1'b0;
      for (int k = 0; k < hs + COLS * CELL_W + 3; k++) step();
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; hsync = 1'b0; vsync = 1'b0; status_top = 1'b0;
    h_offset = '0; v_offset = '0; char_code = 8'h00;
    t_pix = 1000000; l_idx = -1; armed = 1'b0;
    hs_last = 1'b0; vs_last = 1'b0;
    hs_cfg = 0; vs_cfg = 0; salt = 0;
    e_col = 0; e_px = 0; e_row = 0; e_ln = 0;
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      chk(!disp_en && !ctl_blank && mem_row == '0 && mem_col == '0 &&
          glyph_x == '0 && glyph_y == '0, "R9", "reset outputs",
          int'({disp_en, ctl_blank, mem_row, mem_col, glyph_x, glyph_y}), 0);
    end
    rst_n = 1'b1;
    // R9: line syncs before any field sync never enable the display
    repeat (4) step();
    hsync = 1'b1; step(); hsync = 1'b0;
    repeat (COLS * CELL_W + 4) step();

    run_field(0, 0, 1'b0, 8'h14);
    run_field(2, 1, 1'b1, 8'h14);
    run_field(4, 3, 1'b0, 8'hF0);
    run_field(1, 2, 1'b1, 8'h70);
    run_field(3, 0, 1'b1, 8'h18);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule